// File: doc/BRIEF.md
# Task Trigger Flag Register

This block holds one pending flag for each of eight accelerator tasks and hands that vector to a task scheduler. Software raises flags through two separate set paths. The first is a force register on a small register bus. Writing a 1 to one of its bits sets the flag for that task. Writing a 0 leaves the flag alone. The force register only accepts writes while a write-protection unlock input is high.

The second path is an acknowledge-style instruction port. It carries a 16-bit operand and sets flags in the same way as a force write. It needs no unlock, but it works only after software has set an enable bit in a control register. The scheduler clears a flag with a one-cycle pulse on that task's clear line. A set that arrives in the same cycle as a clear wins.

The register bus decodes three locations:

| Address | Register | Read | Write |
|---------|----------|------|-------|
| 0 | Pending flags | current flags in bits 7..0 | ignored |
| 1 | Force | always zero | write-1-to-set, needs unlock |
| 2 | Control | enable in bit 0 | bit 0 is the acknowledge enable |

Reads are combinational and depend on the read strobe.

Top module: `task_trig_flags`

## Requirements
- R1: After reset, every pending flag is 0 and the acknowledge-enable bit (control register, address 2, bit 0) reads 0.
- R2: A bus write to the force register (address 1) while `wp_unlock` is high sets pending flag k for each `bus_wdata` bit k (k = 0..7, task 1 at bit 0) that is 1. The flag is visible on `task_pend` one clock later, and all other flags keep their value.
- R3: A force-register write while `wp_unlock` is low changes no pending flag.
- R4: A read of the force register (address 1) returns 0 in all 16 bits.
- R5: When the acknowledge enable is 1, an `ack_valid` cycle sets the pending flags selected by `ack_operand[7:0]`, whatever the level of `wp_unlock`. `ack_operand[15:8]` is ignored.
- R6: When the acknowledge enable is 0, an `ack_valid` cycle changes no pending flag.
- R7: A `sched_clr` bit k clears pending flag k one clock later. If a set for flag k, from either path, occurs in the same cycle, the flag ends up set.
- R8: Reads of address 0 return the pending flags in bits 7..0 with zeros above. A write to address 2 loads the acknowledge enable from `bus_wdata[0]`; the new value applies from the next cycle. `bus_rdata` is 0 whenever `bus_rd` is low.
- R9: Force-register bits 15..8, and force bits written as 0, have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| wp_unlock | input | 1 | Write-protection unlock for the force register |
| ack_valid | input | 1 | Acknowledge-instruction strobe |
| ack_operand | input | 16 | Acknowledge-instruction operand |
| sched_clr | input | 8 | Per-task clear pulses from the scheduler |
| task_pend | output | 8 | Pending task flags |

## Verification
The assertions check the per-cycle flag rules on every clock:
- a set always leaves its flag high;
- a clear with no set drops the flag;
- with neither, the flag holds;
- a locked force write or a disabled acknowledge adds no flag;
- force reads return zero.

Only the bench scenarios can show the behaviour that depends on bit mapping and history:
- that the right task bits follow from a given operand, with the upper byte and zero bits ignored;
- that the enable bit written earlier gates a later acknowledge;
- that the reset values are correct.

// File: rtl/task_trig_pkg.sv
package task_trig_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND  = 2'd0,
    ADDR_FORCE = 2'd1,
    ADDR_CTRL  = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/task_trig_rst_sync.sv
module task_trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/task_trig_regif.sv
module task_trig_regif
  import task_trig_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                wp_unlock,
  input  logic                ack_valid,
  input  logic [DATA_W-1:0]   ack_operand,
  input  logic [N_TASKS-1:0]  pend,
  output logic [N_TASKS-1:0]  set_vec,
  output logic                ack_en
);
  localparam int PAD_W = DATA_W - N_TASKS;

  logic en_q, en_d;
  logic ctrl_wr, force_wr, ack_fire;
  logic unused_hi;

  assign unused_hi = ^{bus_wdata[DATA_W-1:N_TASKS], ack_operand[DATA_W-1:N_TASKS]};

  always_comb begin
    ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    force_wr = bus_wr && (bus_addr == ADDR_FORCE) && wp_unlock;
    ack_fire = ack_valid && en_q;
    en_d     = en_q;
    if (ctrl_wr) en_d = bus_wdata[0];
    set_vec = '0;
    if (force_wr) set_vec = set_vec | bus_wdata[N_TASKS-1:0];
    if (ack_fire) set_vec = set_vec | ack_operand[N_TASKS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctrl_wr) en_q <= en_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_PEND: bus_rdata = {{PAD_W{1'b0}}, pend};
        ADDR_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign ack_en = en_q;

  assert_force_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_FORCE) |-> (bus_rdata == '0));

  assert_ctrl_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTRL) |=> (ack_en == $past(bus_wdata[0])));
endmodule

// File: rtl/task_trig_bank.sv
module task_trig_bank #(
  parameter int N_TASKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TASKS-1:0] set_vec,
  input  logic [N_TASKS-1:0] clr_vec,
  output logic [N_TASKS-1:0] pend
);
  for (genvar k = 0; k < N_TASKS; k++) begin : g_flag
    logic flag_q, flag_d, flag_ce;

    always_comb begin
      flag_ce = set_vec[k] | clr_vec[k];
      flag_d  = set_vec[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_ce) flag_q <= flag_d;
    end

    assign pend[k] = flag_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[k] |=> pend[k]);
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[k] && !set_vec[k]) |=> !pend[k]);
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[k] && !set_vec[k]) |=> $stable(pend[k]));
  end
endmodule

// File: rtl/task_trig_flags.sv
module task_trig_flags
  import task_trig_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               wp_unlock,
  input  logic               ack_valid,
  input  logic [DATA_W-1:0]  ack_operand,
  input  logic [N_TASKS-1:0] sched_clr,
  output logic [N_TASKS-1:0] task_pend
);
  logic               rst_sync_n;
  logic [N_TASKS-1:0] set_vec;
  logic               ack_en;

  task_trig_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  task_trig_regif #(.N_TASKS(N_TASKS), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wp_unlock(wp_unlock), .ack_valid(ack_valid), .ack_operand(ack_operand),
    .pend(task_pend), .set_vec(set_vec), .ack_en(ack_en)
  );

  task_trig_bank #(.N_TASKS(N_TASKS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .set_vec(set_vec), .clr_vec(sched_clr), .pend(task_pend)
  );

  assert_locked_force_inert_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_FORCE && !wp_unlock && !ack_valid)
      |=> ((task_pend & ~$past(task_pend)) == '0));

  assert_disabled_ack_inert_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_valid && !ack_en && !(bus_wr && bus_addr == ADDR_FORCE))
      |=> ((task_pend & ~$past(task_pend)) == '0));
endmodule

// File: tb/task_trig_flags_bench.sv
module task_trig_flags_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          wp_unlock, ack_valid;
  logic [DW-1:0] ack_operand;
  logic [N-1:0]  sched_clr, task_pend;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] m_pend;
  logic         m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_trig_flags u_task_trig_flags (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wp_unlock(wp_unlock), .ack_valid(ack_valid), .ack_operand(ack_operand),
    .sched_clr(sched_clr), .task_pend(task_pend)
  );

  function automatic logic [DW-1:0] exp_read(input logic rd, input logic [1:0] a);
    if (!rd) return '0;
    case (a)
      2'd0:    return {8'h00, m_pend};
      2'd2:    return {15'h0, m_en};
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] exp_set(input logic wr, input logic [1:0] a,
      input logic [DW-1:0] wd, input logic unl, input logic av, input logic [DW-1:0] op);
    logic [N-1:0] s = '0;
    if (wr && a == 2'd1 && unl) s = s | wd[N-1:0];
    if (av && m_en)             s = s | op[N-1:0];
    return s;
  endfunction

  task automatic check16(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic wr, input logic rd, input logic [1:0] a,
      input logic [DW-1:0] wd, input logic unl, input logic av,
      input logic [DW-1:0] op, input logic [N-1:0] clr);
    logic [N-1:0] s;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    wp_unlock = unl; ack_valid = av; ack_operand = op; sched_clr = clr;
    #1;
    if (rd) check16(req, bus_rdata, exp_read(rd, a));
    s = exp_set(wr, a, wd, unl, av, op);
    m_pend = s | (m_pend & ~clr);
    if (wr && a == 2'd2) m_en = wd[0];
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ack_valid = 0; sched_clr = '0; wp_unlock = 0;
    check16(req, {8'h00, task_pend}, {8'h00, m_pend});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    wp_unlock = 0; ack_valid = 0; ack_operand = 0; sched_clr = 0;
    m_pend = '0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check16("R1 pend", {8'h00, task_pend}, 16'h0000);
    cyc("R1 ctrl read", 0, 1, 2'd2, 16'h0, 0, 0, 16'h0, 8'h00);
    cyc("R8 pend read", 0, 1, 2'd0, 16'h0, 0, 0, 16'h0, 8'h00);
    cyc("R2 R9 force unlocked", 1, 0, 2'd1, 16'hFF05, 1, 0, 16'h0, 8'h00);
    cyc("R4 force read", 0, 1, 2'd1, 16'h0, 1, 0, 16'h0, 8'h00);
    cyc("R3 force locked", 1, 0, 2'd1, 16'h00F0, 0, 0, 16'h0, 8'h00);
    cyc("R6 ack disabled", 0, 0, 2'd0, 16'h0, 1, 1, 16'h0080, 8'h00);
    cyc("R8 ctrl write", 1, 0, 2'd2, 16'h0001, 0, 0, 16'h0, 8'h00);
    cyc("R8 ctrl read", 0, 1, 2'd2, 16'h0, 0, 0, 16'h0, 8'h00);
    cyc("R5 ack no unlock", 0, 0, 2'd0, 16'h0, 0, 1, 16'hAB10, 8'h00);
    cyc("R9 force zeros", 1, 0, 2'd1, 16'h0000, 1, 0, 16'h0, 8'h00);
    cyc("R7 clear", 0, 0, 2'd0, 16'h0, 0, 0, 16'h0, 8'h05);
    cyc("R7 set beats clear", 0, 0, 2'd0, 16'h0, 0, 1, 16'h0010, 8'h10);
    cyc("R7 force beats clear", 1, 0, 2'd1, 16'h0002, 1, 0, 16'h0, 8'h02);
    cyc("R8 pend read back", 0, 1, 2'd0, 16'h0, 0, 0, 16'h0, 8'h00);
    cyc("R8 ctrl off", 1, 0, 2'd2, 16'h0000, 0, 0, 16'h0, 8'h00);
    cyc("R6 ack after disable", 0, 0, 2'd0, 16'h0, 0, 1, 16'h00FF, 8'h00);

    for (int i = 0; i < 400; i++) begin
      cyc("R2 R5 R7 random",
          ($urandom % 3) == 0, ($urandom % 2) == 0, 2'($urandom % 4),
          16'($urandom), ($urandom % 2) == 0, ($urandom % 3) == 0,
          16'($urandom), 8'($urandom & $urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule